// File: doc/BRIEF.md
# Butterfly Wormhole Switching Node

This block is one 2x2 switch of a binary butterfly network. Packets travel as word-sized flits under wormhole flow control. Each of the two input links and two output links carries one data word plus a level-transition ready/acknowledge pair. A sender announces a new flit by inverting its ready line. The receiver accepts it by inverting its acknowledge line, so that the two lines match again.

The first flit of a packet is its heading. The heading holds the destination identifier, the source identifier and the packet length. At stage `STAGE` the node XORs one source bit with the matching destination bit. A result of 0 selects the straight output (output 0) and a result of 1 selects the oblique output (output 1). The node then reserves that output and streams the rest of the packet behind the heading. When two headings compete for the same free output, a round-robin choice decides between them.

Generate-time variants cover three cases. The last stage routes on the destination least significant bit alone. Reverse-direction nodes walk the identifier bits upward from bit 1. Each input holds one flit in a buffer, and each output holds one flit in a register.

Top module: `wh_bfly_node`

## Requirements
- R1: After reset, both input acknowledge lines and both output ready lines are low.
- R2: The heading word carries the destination identifier in bits [ID_W-1:0] and the source identifier in bits [8+ID_W-1:8]. In a forward node that is not the last stage, the heading leaves on output (src[b] XOR dst[b]) with b = ID_W-1-STAGE. Output 0 is the straight link and output 1 is the oblique link.
- R3: Heading bits [23:16] give the packet length in flits, counting the heading. A value of 0 or 1 makes a single-flit packet. Every later flit leaves on the heading's output whatever its content, in the order it arrived.
- R4: From the moment a heading is forwarded until the last flit of its packet is forwarded, that output carries flits of no other packet. Competing headings wait.
- R5: When headings on both inputs want the same free output in the same cycle, the input with priority wins. Input 0 has priority after reset. After each heading grant on an output, priority on that output passes to the other input.
- R6: An input accepts a flit by inverting its acknowledge exactly once per flit. It buffers at most one flit, so when its output is blocked, the next flit after the buffered one is not acknowledged.
- R7: An output announces each flit by inverting its ready line. It holds the data and ready stable until its acknowledge matches ready again.
- R8: Packets from the two inputs to different outputs are forwarded concurrently, and both outputs can have a flit pending at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 2 x DATA_W | Flit word on each input link |
| in_rdy | input | 2 | Per-input ready; toggles to announce a flit |
| in_ack | output | 2 | Per-input acknowledge; toggles when the flit is taken |
| out_data | output | 2 x DATA_W | Flit word on each output link (0 straight, 1 oblique) |
| out_rdy | output | 2 | Per-output ready; toggles to announce a flit |
| out_ack | input | 2 | Per-output acknowledge from the next stage |

## Verification
Wrong internal state shows up at the output ports within a flit or two:
- A stale reservation lets a flit of another packet slip between a heading and its tail. The scoreboard sees this on the very next flit of that output.
- A miscounted length frees the output early or late. This appears either as a heading expected where a body flit arrives, or as a queue left non-empty at the end.
- A wrong round-robin pointer changes which input's heading appears first after simultaneous requests.
- A broken buffer-full flag shows up as an acknowledge that arrives while the downstream link is still blocked.

// File: rtl/wh_bfly_pkg.sv
package wh_bfly_pkg;
   // output port numbering of the 2x2 node
   typedef enum logic {
      PORT_STRAIGHT = 1'b0,
      PORT_OBLIQUE  = 1'b1
   } port_e;

   localparam int NODE_PORTS = 2;
endpackage

// File: rtl/wh_in_port.sv
module wh_in_port
   import wh_bfly_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int ID_W    = 3,
   parameter int STAGE   = 1,
   parameter bit REVERSE = 1'b0,
   parameter int SRC_LSB = 8,
   parameter int DST_LSB = 0,
   parameter int LEN_LSB = 16,
   parameter int LEN_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] lnk_data,
   input  logic              lnk_rdy,
   output logic              lnk_ack,
   input  logic              take,
   output logic              req_valid,
   output logic              req_port,
   output logic              req_head,
   output logic              req_last,
   output logic [DATA_W-1:0] req_flit
);
   localparam bit LAST_STAGE = (STAGE == ID_W - 1);
   localparam int CMP_BIT    = REVERSE ? STAGE + 1 : ID_W - 1 - STAGE;
   localparam logic [LEN_W-1:0] LEN_ONE = {{(LEN_W-1){1'b0}}, 1'b1};

   logic              ack_q;
   logic              buf_v;
   logic [DATA_W-1:0] buf_d;
   logic              head_q;
   logic              route_q;
   logic [LEN_W-1:0]  rem_q;

   logic              arrive;
   logic              load;
   logic              head_port;
   logic [LEN_W-1:0]  pkt_len;
   logic              single;

   // routing decision for a heading flit, variant picked by stage and direction
   generate
      if (LAST_STAGE) begin : g_last
         assign head_port = buf_d[DST_LSB];
      end else begin : g_mid
         assign head_port = buf_d[SRC_LSB + CMP_BIT] ^ buf_d[DST_LSB + CMP_BIT];
      end
   endgenerate

   assign arrive  = lnk_rdy ^ ack_q;
   assign load    = arrive && (!buf_v || take);
   assign pkt_len = buf_d[LEN_LSB +: LEN_W];
   assign single  = (pkt_len <= LEN_ONE);

   assign lnk_ack   = ack_q;
   assign req_valid = buf_v;
   assign req_head  = head_q;
   assign req_port  = head_q ? head_port : route_q;
   assign req_last  = head_q ? single : (rem_q == LEN_ONE);
   assign req_flit  = buf_d;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ack_q   <= 1'b0;
         buf_v   <= 1'b0;
         buf_d   <= '0;
         head_q  <= 1'b1;
         route_q <= PORT_STRAIGHT;
         rem_q   <= '0;
      end else begin
         buf_v <= load | (buf_v & ~take);
         if (load) begin
            buf_d <= lnk_data;
            ack_q <= ~ack_q;
         end
         if (take) begin
            if (head_q) begin
               route_q <= head_port;
               if (!single) begin
                  head_q <= 1'b0;
                  rem_q  <= pkt_len - LEN_ONE;
               end
            end else begin
               rem_q <= rem_q - LEN_ONE;
               if (rem_q == LEN_ONE) head_q <= 1'b1;
            end
         end
      end
   end

   // R6: acknowledge only moves when a flit was announced
   p_ack_on_arrival_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(lnk_rdy ^ lnk_ack) |=> (lnk_ack == $past(lnk_ack)));

   // R6: the output side never takes from an empty buffer
   p_take_has_flit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> req_valid);

   // R4: after the tail flit leaves, the next flit is a heading again
   p_release_after_tail_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !req_head && req_last) |=> req_head);
endmodule

// File: rtl/wh_out_ctl.sv
module wh_out_ctl
   import wh_bfly_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [NODE_PORTS-1:0]             head_req,
   input  logic [NODE_PORTS-1:0]             body_req,
   input  logic [NODE_PORTS-1:0]             last,
   input  logic [NODE_PORTS-1:0][DATA_W-1:0] flit,
   output logic [NODE_PORTS-1:0]             gnt,
   output logic [DATA_W-1:0]                lnk_data,
   output logic                             lnk_rdy,
   input  logic                             lnk_ack
);
   logic              rdy_q;
   logic [DATA_W-1:0] data_q;
   logic              lock_q;
   logic              owner_q;
   logic              prio_q;

   logic              free;
   logic              any;
   logic              sel;

   assign free     = (rdy_q == lnk_ack);
   assign lnk_rdy  = rdy_q;
   assign lnk_data = data_q;

   always_comb begin
      gnt = '0;
      if (free) begin
         if (lock_q) begin
            gnt[owner_q] = body_req[owner_q];
         end else if (head_req[prio_q]) begin
            gnt[prio_q] = 1'b1;
         end else if (head_req[~prio_q]) begin
            gnt[~prio_q] = 1'b1;
         end
      end
   end

   assign any = |gnt;
   assign sel = gnt[1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdy_q   <= 1'b0;
         data_q  <= '0;
         lock_q  <= 1'b0;
         owner_q <= 1'b0;
         prio_q  <= 1'b0;
      end else if (any) begin
         data_q <= flit[sel];
         rdy_q  <= ~rdy_q;
         if (!lock_q) prio_q <= ~sel;
         if (last[sel]) begin
            lock_q <= 1'b0;
         end else if (!lock_q) begin
            lock_q  <= 1'b1;
            owner_q <= sel;
         end
      end
   end

   // R7: a pending flit is held until the next stage acknowledges it
   p_hold_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (lnk_rdy != lnk_ack) |=> ($stable(lnk_data) && $stable(lnk_rdy)));

   // R4: at most one input drives this output in a cycle
   p_one_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));

   // R4: a reserved output serves only its owner
   p_lock_owner_r4: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |-> !gnt[~owner_q]);

   // R5: a contested heading grant hands priority to the other input
   p_rr_turn_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (any && !lock_q && (head_req == 2'b11)) |=> (prio_q != $past(prio_q)));
endmodule

// File: rtl/wh_bfly_node.sv
module wh_bfly_node
   import wh_bfly_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int ID_W    = 3,
   parameter int STAGE   = 1,
   parameter bit REVERSE = 1'b0,
   parameter int SRC_LSB = 8,
   parameter int DST_LSB = 0,
   parameter int LEN_LSB = 16,
   parameter int LEN_W   = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [1:0][DATA_W-1:0] in_data,
   input  logic [1:0]             in_rdy,
   output logic [1:0]             in_ack,
   output logic [1:0][DATA_W-1:0] out_data,
   output logic [1:0]             out_rdy,
   input  logic [1:0]             out_ack
);
   localparam int ID_END  = (SRC_LSB > DST_LSB ? SRC_LSB : DST_LSB) + ID_W;
   localparam int LEN_END = LEN_LSB + LEN_W;

   initial begin
      assert (ID_W >= 1) else $error("ID_W must be at least 1");
      assert (STAGE >= 0 && STAGE < ID_W) else $error("STAGE out of range");
      assert (ID_END <= DATA_W && LEN_END <= DATA_W) else $error("heading fields exceed DATA_W");
      assert (LEN_W >= 2) else $error("LEN_W too small");
   end

   logic [NODE_PORTS-1:0]             rq_valid;
   logic [NODE_PORTS-1:0]             rq_port;
   logic [NODE_PORTS-1:0]             rq_head;
   logic [NODE_PORTS-1:0]             rq_last;
   logic [NODE_PORTS-1:0][DATA_W-1:0] rq_flit;
   logic [NODE_PORTS-1:0]             take;
   logic [NODE_PORTS-1:0]             gnt_o [NODE_PORTS];

   generate
      for (genvar gi = 0; gi < NODE_PORTS; gi++) begin : g_in
         wh_in_port #(
            .DATA_W (DATA_W),  .ID_W   (ID_W),    .STAGE  (STAGE),
            .REVERSE(REVERSE), .SRC_LSB(SRC_LSB), .DST_LSB(DST_LSB),
            .LEN_LSB(LEN_LSB), .LEN_W  (LEN_W)
         ) u_in (
            .clk      (clk),
            .rst_n    (rst_n),
            .lnk_data (in_data[gi]),
            .lnk_rdy  (in_rdy[gi]),
            .lnk_ack  (in_ack[gi]),
            .take     (take[gi]),
            .req_valid(rq_valid[gi]),
            .req_port (rq_port[gi]),
            .req_head (rq_head[gi]),
            .req_last (rq_last[gi]),
            .req_flit (rq_flit[gi])
         );
         assign take[gi] = gnt_o[0][gi] | gnt_o[1][gi];
      end

      for (genvar go = 0; go < NODE_PORTS; go++) begin : g_out
         logic [NODE_PORTS-1:0] hreq;
         logic [NODE_PORTS-1:0] breq;
         for (genvar gk = 0; gk < NODE_PORTS; gk++) begin : g_req
            assign hreq[gk] = rq_valid[gk] &  rq_head[gk] & (rq_port[gk] == go[0]);
            assign breq[gk] = rq_valid[gk] & ~rq_head[gk] & (rq_port[gk] == go[0]);
         end
         wh_out_ctl #(.DATA_W(DATA_W)) u_out (
            .clk     (clk),
            .rst_n   (rst_n),
            .head_req(hreq),
            .body_req(breq),
            .last    (rq_last),
            .flit    (rq_flit),
            .gnt     (gnt_o[go]),
            .lnk_data(out_data[go]),
            .lnk_rdy (out_rdy[go]),
            .lnk_ack (out_ack[go])
         );
      end
   endgenerate

   // R4: one input's flit is never granted to both outputs
   p_single_dest_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(gnt_o[0] & gnt_o[1])));
endmodule

// File: tb/wh_bfly_node_tb.sv
module wh_bfly_node_tb_top;
   localparam int DW    = 32;
   localparam int ID_W  = 3;
   localparam int STAGE = 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [1:0][DW-1:0] in_data = '0;
   logic [1:0]        in_rdy = '0;
   logic [1:0]        in_ack;
   logic [1:0][DW-1:0] out_data;
   logic [1:0]        out_rdy;
   logic [1:0]        out_ack = '0;

   always #10 clk = ~clk;

   wh_bfly_node #(.DATA_W(DW), .ID_W(ID_W), .STAGE(STAGE)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .in_data(in_data), .in_rdy(in_rdy), .in_ack(in_ack),
      .out_data(out_data), .out_rdy(out_rdy), .out_ack(out_ack)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;
   int pid = 0;
   logic [31:0] expq [2][2][$];
   int cur_src [2] = '{-1, -1};
   int left [2] = '{0, 0};
   int slow [2] = '{1, 1};
   int ord [2][64];
   int ordn [2] = '{0, 0};
   bit both_pend = 0;

   function automatic int eport(input int s, input int d);
      int b = ID_W - 1 - STAGE;
      return ((s >> b) & 1) ^ ((d >> b) & 1);
   endfunction

   function automatic int nflits(input logic [31:0] h);
      int l = int'(h[23:16]);
      return (l <= 1) ? 1 : l;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic drive_flit(input int i, input logic [31:0] w, output int waited);
      @(negedge clk);
      in_data[i] = w;
      in_rdy[i] = ~in_rdy[i];
      waited = 0;
      do begin
         @(negedge clk);
         waited++;
      end while (in_ack[i] != in_rdy[i]);
      @(negedge clk);
      chk(in_ack[i] == in_rdy[i], "R6", "single ack toggle", {31'd0, in_ack[i]}, {31'd0, in_rdy[i]});
   endtask

   // builds a packet, queues its flits on the expected output, then sends them
   task automatic send_pkt(input int i, input int s, input int d, input int len,
                           input bit lookalike, output int w2);
      logic [31:0] q[$];
      int p = eport(s, d);
      int n = (len <= 1) ? 1 : len;
      int wt;
      logic [7:0] id = 8'(pid);
      pid++;
      q.push_back({id, 8'(len), 8'(s), 8'(d)});
      for (int k = 1; k < n; k++) begin
         if (lookalike)
            q.push_back({id, 8'(len), 8'(s ^ 2), 8'(d) ^ 8'(k)});
         else
            q.push_back({id, 8'hEE, 8'(k), 8'(i)});
      end
      foreach (q[k]) expq[p][i].push_back(q[k]);
      w2 = 0;
      foreach (q[k]) begin
         drive_flit(i, q[k], wt);
         if (k == 2) w2 = wt;
      end
   endtask

   task automatic mon(input int o);
      logic [31:0] w;
      forever begin
         @(negedge clk);
         if (out_rdy[o] != out_ack[o]) begin
            w = out_data[o];
            if (cur_src[o] < 0) begin
               int j = -1;
               for (int k = 0; k < 2; k++)
                  if (j < 0 && expq[o][k].size() > 0 && expq[o][k][0] == w) j = k;
               chk(j >= 0, "R2", $sformatf("heading on out%0d", o), w,
                   expq[o][0].size() > 0 ? expq[o][0][0] : 32'hx);
               if (j >= 0) begin
                  void'(expq[o][j].pop_front());
                  if (ordn[o] < 64) ord[o][ordn[o]] = j;
                  ordn[o]++;
                  left[o] = nflits(w) - 1;
                  if (left[o] > 0) cur_src[o] = j;
               end
            end else begin
               int j = cur_src[o];
               logic [31:0] e = expq[o][j].size() > 0 ? expq[o][j][0] : 32'hx;
               chk(expq[o][j].size() > 0 && e == w, "R4", $sformatf("body flit on out%0d", o), w, e);
               if (expq[o][j].size() > 0) void'(expq[o][j].pop_front());
               left[o]--;
               if (left[o] == 0) cur_src[o] = -1;
            end
            repeat (slow[o]) @(negedge clk);
            chk(out_data[o] == w, "R7", $sformatf("out%0d data held", o), out_data[o], w);
            out_ack[o] = ~out_ack[o];
         end
      end
   endtask

   always @(negedge clk)
      if ((out_rdy[0] != out_ack[0]) && (out_rdy[1] != out_ack[1])) both_pend = 1;

   task automatic wait_idle();
      do @(negedge clk);
      while (!(expq[0][0].size() == 0 && expq[0][1].size() == 0 &&
               expq[1][0].size() == 0 && expq[1][1].size() == 0 &&
               cur_src[0] < 0 && cur_src[1] < 0 && out_rdy == out_ack));
      repeat (3) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      int w2, w2b;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(in_ack == 2'b00, "R1", "in_ack after reset", {30'd0, in_ack}, 32'd0);
      chk(out_rdy == 2'b00, "R1", "out_rdy after reset", {30'd0, out_rdy}, 32'd0);

      fork
         mon(0);
         mon(1);
      join_none

      // R5: contention from reset, input 0 first
      fork
         send_pkt(0, 0, 0, 3, 0, w2);
         send_pkt(1, 1, 5, 3, 0, w2b);
      join
      wait_idle();
      chk(ord[0][0] == 0 && ord[0][1] == 1, "R5", "first contention order",
          32'(ord[0][0] * 16 + ord[0][1]), 32'h01);
      send_pkt(0, 4, 0, 2, 0, w2);
      wait_idle();
      fork
         send_pkt(0, 0, 1, 3, 0, w2);
         send_pkt(1, 3, 7, 3, 0, w2b);
      join
      wait_idle();
      chk(ord[0][3] == 1 && ord[0][4] == 0, "R5", "rotated contention order",
          32'(ord[0][3] * 16 + ord[0][4]), 32'h10);

      // R6: one-flit buffer stalls a third flit behind a blocked output
      slow[0] = 30;
      send_pkt(0, 0, 0, 4, 0, w2);
      chk(w2 >= 20, "R6", "third flit ack delayed by blocked output", 32'(w2), 32'd20);
      wait_idle();
      slow[0] = 1;

      // R2: route sweep across source/destination pairs
      for (int s = 0; s < 8; s += 3)
         for (int d = 0; d < 8; d++) begin
            send_pkt(s % 2, s, d, 2, 0, w2);
         end
      wait_idle();

      // R8: concurrent traffic on both outputs
      both_pend = 0;
      slow[0] = 2;
      slow[1] = 2;
      fork
         send_pkt(0, 1, 1, 8, 0, w2);
         send_pkt(1, 0, 2, 8, 0, w2b);
      join
      wait_idle();
      chk(both_pend, "R8", "both outputs pending together", {31'd0, both_pend}, 32'd1);
      slow[0] = 1;
      slow[1] = 1;

      // R3: zero/one length packets and heading-like body flits
      send_pkt(0, 0, 2, 0, 0, w2);
      send_pkt(0, 0, 2, 1, 0, w2);
      send_pkt(1, 2, 2, 4, 1, w2);
      send_pkt(0, 6, 4, 5, 1, w2);
      wait_idle();

      for (int o = 0; o < 2; o++)
         for (int i = 0; i < 2; i++)
            chk(expq[o][i].size() == 0, "R3", $sformatf("queue out%0d in%0d drained", o, i),
                32'(expq[o][i].size()), 32'd0);
      finish_run();
   end
endmodule